// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit

This block is the multi-cycle arithmetic engine of a small processor core. It performs unsigned multiplication and unsigned restoring division, each in a short and a long operand-width form. A one-cycle `start` pulse captures the operation select and both operands. The unit then works for a fixed number of clock cycles that depends only on the operation, never on the data. At the end it raises a one-cycle `done` pulse. The product, or the quotient and remainder, stay on the result ports until the next accepted start.

Both datapaths retire two operand bits per clock. This fits every operation inside its cycle budget. When the arithmetic finishes early, the controller pads the remaining cycles so that the latency is exact. Division by zero needs no special path. The restoring iteration, fed a zero divisor, already yields an all-ones quotient and passes the dividend's low bits through as the remainder. A separate flag reports the condition.

The controller has two states. ST_IDLE waits for work, and start moves it to ST_CALC (transition "accept"). ST_CALC counts the cycle budget down and returns to ST_IDLE when the count reaches zero (transition "finish"), which also issues `done`. A start seen in ST_CALC causes no transition.

Top module: `seq_muldiv`

## Requirements
- R1: With op = 2'b00 the unit multiplies opa[15:0] by opb[7:0] and places the 24-bit product on product[23:0], with product[39:24] zero. opa[23:16] and opb[15:8] have no effect.
- R2: With op = 2'b01 the unit multiplies opa[23:0] by opb[15:0] and places the full 40-bit product on product.
- R3: With op = 2'b10 and a non-zero opb[7:0], quotient[15:0] = opa[15:0] / opb[7:0] and remainder[7:0] = opa[15:0] mod opb[7:0]. quotient[23:16] and remainder[15:8] are zero, and opa[23:16] and opb[15:8] have no effect.
- R4: With op = 2'b11 and a non-zero opb, quotient = opa / opb (24 bits) and remainder = opa mod opb (16 bits).
- R5: `done` rises exactly N clock edges after the edge that accepts start: N = 5 for op 00, 12 for op 01, 8 for op 10 and 12 for op 11. `busy` is high for exactly those N cycles and falls on the edge where `done` rises.
- R6: A divide with a zero divisor (opb[7:0] for op 10, opb for op 11) sets div_err. The quotient is all ones across the dividend width (24'h00FFFF or 24'hFFFFFF). The remainder equals the dividend's low bits at the divisor width. The latency is unchanged. Any other accepted operation clears div_err.
- R7: A start pulse while busy is high is ignored: the running operation keeps its operands, its result and its latency.
- R8: `done` is high for one cycle only. product, quotient, remainder and div_err hold their values until the next accepted start.
- R9: After reset, busy, done and div_err are 0, and product, quotient and remainder are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request that captures op, opa and opb |
| op | input | 2 | 00 short multiply, 01 long multiply, 10 short divide, 11 long divide |
| opa | input | 24 | Multiplicand or dividend |
| opb | input | 16 | Multiplier or divisor |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last divide had a zero divisor |
| product | output | 40 | Multiply result |
| quotient | output | 24 | Divide quotient |
| remainder | output | 16 | Divide remainder |

## Verification
The bench uses the default parameters: 24/16-bit long operands, 16/8-bit short operands, two bits retired per cycle and cycle budgets of 5, 12, 8 and 12. With these values the multiply forms finish their arithmetic before the budget runs out, so the padding cycles are exercised. The long divide uses every one of its cycles for arithmetic, which brings within reach both an early done and an off-by-one step count. The short forms mask the operand upper bits, so filled upper bits would show any leak into the result.

// File: rtl/smd_pkg.sv
package smd_pkg;
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_L = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_L = 2'b11
    } smd_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CALC = 1'b1
    } smd_state_e;
endpackage

// File: rtl/smd_ctrl.sv
module smd_ctrl
    import smd_pkg::*;
#(
    parameter int LAT_MS = 5,
    parameter int LAT_ML = 12,
    parameter int LAT_DS = 8,
    parameter int LAT_DL = 12,
    parameter int STP_MS = 4,
    parameter int STP_ML = 8,
    parameter int STP_DS = 8,
    parameter int STP_DL = 12,
    parameter int CW     = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  smd_op_e op,
    output logic    load,
    output logic    step_en,
    output logic    busy,
    output logic    done,
    output smd_op_e op_q
);
    smd_state_e     state_q, state_d;
    logic [CW-1:0]  cyc_q, step_q;
    logic [CW-1:0]  lat_sel, stp_sel;
    logic           done_q;

    always_comb begin
        unique case (op)
            OP_MUL_S: begin lat_sel = CW'(LAT_MS - 1); stp_sel = CW'(STP_MS); end
            OP_MUL_L: begin lat_sel = CW'(LAT_ML - 1); stp_sel = CW'(STP_ML); end
            OP_DIV_S: begin lat_sel = CW'(LAT_DS - 1); stp_sel = CW'(STP_DS); end
            OP_DIV_L: begin lat_sel = CW'(LAT_DL - 1); stp_sel = CW'(STP_DL); end
            default:  begin lat_sel = '0; stp_sel = '0; end
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CALC;
            ST_CALC: if (cyc_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            step_q <= '0;
            done_q <= 1'b0;
            op_q   <= OP_MUL_S;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= op;
                        cyc_q  <= lat_sel;
                        step_q <= stp_sel;
                    end
                end
                ST_CALC: begin
                    if (cyc_q == '0) done_q <= 1'b1;
                    else             cyc_q  <= cyc_q - 1'b1;
                    if (step_q != '0) step_q <= step_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign load    = (state_q == ST_IDLE) && start;
    assign step_en = (state_q == ST_CALC) && (step_q != '0);
    assign busy    = (state_q == ST_CALC);
    assign done    = done_q;

    assert_start_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && $past(busy)));
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cyc_q != '0) |=> (busy && op_q == $past(op_q)));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/smd_mul_dp.sv
module smd_mul_dp #(
    parameter int A_W = 24,
    parameter int B_W = 16,
    parameter int A_S = 16,
    parameter int B_S = 8,
    parameter int SB  = 2,
    localparam int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           short_mode,
    input  logic           step_en,
    input  logic [A_W-1:0] opa,
    input  logic [B_W-1:0] opb,
    output logic [P_W-1:0] prod
);
    logic [P_W-1:0] mcand_q, mcand_d;
    logic [B_W-1:0] mplier_q, mplier_d;
    logic [P_W-1:0] prod_q, prod_d;

    // SB multiplier bits retired per step
    always_comb begin
        mcand_d  = mcand_q;
        mplier_d = mplier_q;
        prod_d   = prod_q;
        for (int j = 0; j < SB; j++) begin
            if (mplier_d[0]) prod_d = prod_d + mcand_d;
            mcand_d  = mcand_d << 1;
            mplier_d = mplier_d >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
        end else if (load) begin
            mcand_q  <= short_mode ? P_W'(opa[A_S-1:0]) : P_W'(opa);
            mplier_q <= short_mode ? B_W'(opb[B_S-1:0]) : opb;
            prod_q   <= '0;
        end else if (step_en) begin
            mcand_q  <= mcand_d;
            mplier_q <= mplier_d;
            prod_q   <= prod_d;
        end
    end

    assign prod = prod_q;

    // once the multiplier has drained, the product must not move
    assert_prod_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mplier_q == '0 && !load) |=> $stable(prod_q));
endmodule

// File: rtl/smd_div_dp.sv
module smd_div_dp #(
    parameter int A_W = 24,
    parameter int B_W = 16,
    parameter int A_S = 16,
    parameter int B_S = 8,
    parameter int SB  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           short_mode,
    input  logic           step_en,
    input  logic [A_W-1:0] opa,
    input  logic [B_W-1:0] opb,
    output logic [A_W-1:0] dvd,
    output logic [B_W-1:0] rem
);
    logic [A_W-1:0] dvd_q, dvd_d;
    logic [B_W-1:0] rem_q, rem_d;
    logic [B_W-1:0] dsr_q;
    logic [B_W:0]   trial;
    logic           qbit;

    // SB restoring-division steps per cycle
    always_comb begin
        dvd_d = dvd_q;
        rem_d = rem_q;
        trial = '0;
        qbit  = 1'b0;
        for (int j = 0; j < SB; j++) begin
            trial = {rem_d, dvd_d[A_W-1]};
            if (trial >= {1'b0, dsr_q}) begin
                trial = trial - {1'b0, dsr_q};
                qbit  = 1'b1;
            end else begin
                qbit  = 1'b0;
            end
            rem_d = trial[B_W-1:0];
            dvd_d = {dvd_d[A_W-2:0], qbit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
        end else if (load) begin
            dvd_q <= short_mode ? {opa[A_S-1:0], {(A_W-A_S){1'b0}}} : opa;
            dsr_q <= short_mode ? B_W'(opb[B_S-1:0]) : opb;
            rem_q <= '0;
        end else if (step_en) begin
            dvd_q <= dvd_d;
            rem_q <= rem_d;
        end
    end

    assign dvd = dvd_q;
    assign rem = rem_q;

    assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dsr_q != '0) |-> (rem_q < dsr_q));
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
    import smd_pkg::*;
#(
    parameter int A_W    = 24,
    parameter int B_W    = 16,
    parameter int A_S    = 16,
    parameter int B_S    = 8,
    parameter int SB     = 2,
    parameter int LAT_MS = 5,
    parameter int LAT_ML = 12,
    parameter int LAT_DS = 8,
    parameter int LAT_DL = 12,
    localparam int P_W   = A_W + B_W,
    localparam int P_S   = A_S + B_S
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     op,
    input  logic [A_W-1:0] opa,
    input  logic [B_W-1:0] opb,
    output logic           busy,
    output logic           done,
    output logic           div_err,
    output logic [P_W-1:0] product,
    output logic [A_W-1:0] quotient,
    output logic [B_W-1:0] remainder
);
    localparam int STP_MS = (B_S + SB - 1) / SB;
    localparam int STP_ML = (B_W + SB - 1) / SB;
    localparam int STP_DS = (A_S + SB - 1) / SB;
    localparam int STP_DL = (A_W + SB - 1) / SB;
    localparam int MAX_AB = (LAT_MS > LAT_ML) ? LAT_MS : LAT_ML;
    localparam int MAX_CD = (LAT_DS > LAT_DL) ? LAT_DS : LAT_DL;
    localparam int MAXLAT = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXLAT + 1);

    smd_op_e        op_in, op_q;
    logic           load, step_en;
    logic           mul_step, div_step;
    logic           err_q;
    logic [P_W-1:0] prod_w;
    logic [A_W-1:0] dvd_w;
    logic [B_W-1:0] rem_w;
    logic           zero_dsr;

    assign op_in = smd_op_e'(op);

    smd_ctrl #(
        .LAT_MS(LAT_MS), .LAT_ML(LAT_ML), .LAT_DS(LAT_DS), .LAT_DL(LAT_DL),
        .STP_MS(STP_MS), .STP_ML(STP_ML), .STP_DS(STP_DS), .STP_DL(STP_DL),
        .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_in),
        .load(load), .step_en(step_en), .busy(busy), .done(done), .op_q(op_q)
    );

    assign mul_step = step_en && !op_q[1];
    assign div_step = step_en &&  op_q[1];

    smd_mul_dp #(.A_W(A_W), .B_W(B_W), .A_S(A_S), .B_S(B_S), .SB(SB)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(load && !op[1]), .short_mode(op == OP_MUL_S),
        .step_en(mul_step), .opa(opa), .opb(opb), .prod(prod_w)
    );

    smd_div_dp #(.A_W(A_W), .B_W(B_W), .A_S(A_S), .B_S(B_S), .SB(SB)) u_div (
        .clk(clk), .rst_n(rst_n), .load(load && op[1]), .short_mode(op == OP_DIV_S),
        .step_en(div_step), .opa(opa), .opb(opb), .dvd(dvd_w), .rem(rem_w)
    );

    assign zero_dsr = (op == OP_DIV_S) ? (opb[B_S-1:0] == '0) : (opb == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (load) err_q <= op[1] && zero_dsr;
    end

    assign div_err   = err_q;
    assign product   = (op_q == OP_MUL_S) ? P_W'(prod_w[P_S-1:0]) : prod_w;
    assign quotient  = (op_q == OP_DIV_S) ? A_W'(dvd_w[A_S-1:0]) : dvd_w;
    assign remainder = (op_q == OP_DIV_S) ? B_W'(rem_w[B_S-1:0]) : rem_w;

    assert_err_only_on_divide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !op[1]) |=> !div_err);
endmodule

// File: tb/test_seq_muldiv.sv
module test_seq_muldiv;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [23:0] opa = '0;
    logic [15:0] opb = '0;
    logic        busy, done, div_err;
    logic [39:0] product;
    logic [23:0] quotient;
    logic [15:0] remainder;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_muldiv i_seq_muldiv (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .div_err(div_err),
        .product(product), .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [1:0] o);
        case (o)
            2'b00:   return 5;
            2'b01:   return 12;
            2'b10:   return 8;
            default: return 12;
        endcase
    endfunction

    // Runs one operation; if intr > 0 a foreign start is pulsed after that many cycles (R7)
    task automatic run_op(input logic [1:0] o, input logic [23:0] a, input logic [15:0] b, input int intr);
        logic [63:0] ep, eq, er, ea, eb;
        bit ee;
        int lat;
        bit busy_ok;
        ea = 64'(a);
        eb = 64'(b);
        ee = 1'b0;
        ep = '0; eq = '0; er = '0;
        case (o)
            2'b00: ep = (ea & 64'hFFFF) * (eb & 64'hFF);
            2'b01: ep = ea * eb;
            2'b10: begin
                if ((eb & 64'hFF) == 0) begin ee = 1; eq = 64'hFFFF; er = ea & 64'hFF; end
                else begin eq = (ea & 64'hFFFF) / (eb & 64'hFF); er = (ea & 64'hFFFF) % (eb & 64'hFF); end
            end
            default: begin
                if (eb == 0) begin ee = 1; eq = 64'hFFFFFF; er = ea & 64'hFFFF; end
                else begin eq = ea / eb; er = ea % eb; end
            end
        endcase
        @(negedge clk);
        op = o; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op = ~o; opa = ~a; opb = ~b;
        lat = 0;
        busy_ok = 1'b1;
        while (!done && lat < 100) begin
            if (!busy) busy_ok = 1'b0;
            if (intr > 0 && lat == intr) begin
                op = ~o; opa = 24'h123456; opb = 16'h0007; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(lat == lat_of(o), "R5 latency", 64'(lat), 64'(lat_of(o)));
        chk(busy_ok && !busy, "R5 busy window", {63'b0, busy}, 64'h0);
        if (!o[1]) begin
            chk(product == ep[39:0], (o == 2'b00) ? "R1 short product" : "R2 long product",
                64'(product), ep);
        end else begin
            chk(quotient == eq[23:0], ee ? "R6 zero-divisor quotient" :
                ((o == 2'b10) ? "R3 short quotient" : "R4 long quotient"), 64'(quotient), eq);
            chk(remainder == er[15:0], ee ? "R6 zero-divisor remainder" :
                ((o == 2'b10) ? "R3 short remainder" : "R4 long remainder"), 64'(remainder), er);
        end
        chk(div_err == ee, "R6 div_err", {63'b0, div_err}, {63'b0, ee});
    endtask

    task automatic t_reset();
        chk(!busy && !done && !div_err, "R9 reset flags", {61'b0, busy, done, div_err}, 64'h0);
        chk(product == '0 && quotient == '0 && remainder == '0, "R9 reset results",
            64'(product), 64'h0);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 12; i++) begin
            logic [31:0] h1, h2;
            h1 = (i + 1) * 32'h9E3779B1;
            h2 = (i + 7) * 32'h85EBCA6B;
            run_op(2'b00, h1[23:0], h2[15:0], 0);
            run_op(2'b01, h1[31:8], h2[31:16], 0);
            run_op(2'b10, h2[23:0], h1[15:0] | 16'h0001, 0);
            run_op(2'b11, h1[23:0], h2[15:0] | 16'h0001, 0);
        end
    endtask

    task automatic t_boundaries();
        run_op(2'b00, 24'hFFFFFF, 16'hFFFF, 0);   // R1 upper operand bits ignored, max values
        run_op(2'b01, 24'hFFFFFF, 16'hFFFF, 0);   // R2 max values
        run_op(2'b01, 24'h000000, 16'hFFFF, 0);   // R2 zero multiplicand
        run_op(2'b10, 24'hAB00FF, 16'h7701, 0);   // R3 divide by one
        run_op(2'b10, 24'h000003, 16'h00F0, 0);   // R3 dividend below divisor
        run_op(2'b11, 24'hFFFFFF, 16'h0001, 0);   // R4 divide by one
        run_op(2'b11, 24'h00FFFE, 16'hFFFF, 0);   // R4 dividend below divisor
        run_op(2'b11, 24'hFFFFFF, 16'hFFFF, 0);   // R4 max values
    endtask

    task automatic t_div_zero();
        run_op(2'b10, 24'h12C3A5, 16'h5500, 0);   // R6 short: low divisor byte zero
        run_op(2'b11, 24'hC0FFEE, 16'h0000, 0);   // R6 long
        run_op(2'b00, 24'h000010, 16'h0010, 0);   // R6 cleared by multiply
    endtask

    task automatic t_busy_start();
        run_op(2'b01, 24'h00BEEF, 16'h1234, 3);   // R7
        run_op(2'b11, 24'hFACADE, 16'h0123, 5);   // R7
        run_op(2'b00, 24'h00ABCD, 16'h00EF, 4);   // R7 interruption on the last busy cycle
    endtask

    task automatic t_hold();
        logic [39:0] p0;
        logic [23:0] q0;
        logic [15:0] r0;
        logic e0;
        run_op(2'b11, 24'h00AAAA, 16'h0000, 0);
        p0 = product; q0 = quotient; r0 = remainder; e0 = div_err;
        @(negedge clk);
        chk(!done, "R8 done single cycle", {63'b0, done}, 64'h0);
        repeat (4) @(negedge clk);
        chk(quotient == q0 && remainder == r0 && product == p0 && div_err == e0,
            "R8 results held", 64'(quotient), 64'(q0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_boundaries();
        t_div_zero();
        t_busy_start();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule